// File: doc/BRIEF.md
# Vector Float to Unsigned Fixed-Point Saturating Converter

This block turns a 128-bit vector holding four IEEE-754 single-precision values into four unsigned 32-bit fixed-point words. Every lane is scaled by two raised to a 5-bit scale value, cut toward zero, and clamped into the unsigned 32-bit range. Scaling is done by offsetting the exponent before the float-to-integer shift, so no multiplier is needed.

A conversion is started by raising `in_valid` with the operand, the scale and the denormal flush mode. The converted vector and `out_valid` appear on the next clock edge. A sticky saturation flag records that some lane had to be clamped in any conversion. It stays set until `sat_clr` is raised. Decode, register storage and other rounding modes belong to the surrounding pipeline.

Top module: `vfx_ucvt`

## Requirements
- R1: Lane 0 is `src[127:96]` and its result is `result[127:96]`. Lane k uses bits `127-32k` down to `96-32k` of both vectors, and each lane converts independently.
- R2: For a positive finite lane whose scaled value is below 2^32, the result is the value times 2^scale, truncated toward zero. A positive value that truncates to 0 gives 0 and does not set the flag.
- R3: A positive lane whose scaled value is at or above 2^32, and positive infinity (0x7F800000), give 0xFFFFFFFF and set the saturation flag.
- R4: A negative lane gives 0. It sets the flag only if its scaled magnitude truncates to a nonzero value, which includes negative infinity (0xFF800000). -0.0 and small negatives that truncate to zero do not set it.
- R5: A NaN lane (exponent field all ones, fraction nonzero) gives 0 and sets the saturation flag.
- R6: The saturation flag is sticky. It is set after any conversion with a clamped lane and is never cleared by a later conversion. `sat_clr` clears it on the next edge, unless a saturating conversion arrives in the same cycle, in which case the flag stays set.
- R7: A denormal lane (exponent field zero) gives 0 and never sets the flag. With `flush_dn`=1 it is treated as zero. With `flush_dn`=0 it is converted exactly, and because the scale is at most 31 it still truncates to 0.
- R8: `out_valid` is high exactly in the cycle after an `in_valid` cycle. `result` changes only on a cycle with `in_valid` and holds its value otherwise.
- R9: While `rst_n` is low, `out_valid`, `result` and the saturation flag are all 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand valid, starts a conversion |
| src | input | 128 | Four single-precision lanes, lane 0 in the top word |
| scale | input | 5 | Power-of-two scale, 0 to 31 |
| flush_dn | input | 1 | 1: denormal lanes are treated as zero |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 128 | Four unsigned 32-bit fixed-point words |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bound checker watches the timing and flag rules on every cycle. These are the one-cycle valid latency, the hold of the result between conversions, the stickiness of the flag and the priority of a set over a clear. It also checks that every negative or NaN lane comes out as 0 and that any all-ones lane is paired with a set flag. The exact arithmetic can only be shown by the directed scenarios: the truncated products at several scales, the boundary just below 2^32, the overflow at scale 31, the negative values just either side of truncating to zero, and denormals in both flush modes. Their expected words are worked out by hand from the requirements.

// File: rtl/vfx_ucvt.sv
module vfx_ucvt #(
  parameter int LANES = 4,
  parameter int LW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LANES*LW-1:0] src,
  input  logic [4:0]        scale,
  input  logic              flush_dn,
  input  logic              sat_clr,
  output logic              out_valid,
  output logic [LANES*LW-1:0] result,
  output logic              sat_flag
);
  localparam int VW = LANES * LW;

  function automatic logic [32:0] cvt(input logic [31:0] f, input logic [4:0] s, input logic fl);
    logic              sg;
    logic [7:0]        ex;
    logic [23:0]       sig;
    logic signed [9:0] sh;
    logic [9:0]        nsh;
    logic [31:0]       mag;
    logic              ovf;
    sg  = f[31];
    ex  = f[30:23];
    sig = (ex == 8'd0 && fl) ? 24'd0 : {ex != 8'd0, f[22:0]};
    sh  = 10'({2'b00, (ex == 8'd0) ? 8'd1 : ex}) + 10'({5'b0, s}) - 10'sd150;
    nsh = 10'd0 - sh;
    ovf = 1'b0;
    mag = 32'd0;
    if (sh >= 10'sd9)
      ovf = (sig != 24'd0);
    else if (sh >= 10'sd0)
      mag = {8'd0, sig} << sh[3:0];
    else if (sh > -10'sd24)
      mag = {8'd0, sig} >> nsh[4:0];
    if (ex == 8'hFF)
      cvt = (f[22:0] != 23'd0 || sg) ? {1'b1, 32'd0} : {1'b1, 32'hFFFF_FFFF};
    else if (sg)
      cvt = {ovf || mag != 32'd0, 32'd0};
    else
      cvt = ovf ? {1'b1, 32'hFFFF_FFFF} : {1'b0, mag};
  endfunction

  logic [VW-1:0]    conv;
  logic [LANES-1:0] lane_sat;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign {lane_sat[i], conv[VW-1-LW*i -: LW]} = cvt(src[VW-1-LW*i -: LW], scale, flush_dn);
  end

  wire any_sat = in_valid && (|lane_sat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= conv;
      sat_flag <= (sat_flag && !sat_clr) || any_sat;
    end
  end
endmodule

// File: rtl/vfx_ucvt_chk.sv
module vfx_ucvt_chk #(
  parameter int LANES = 4,
  parameter int LW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [LANES*LW-1:0] src,
  input logic              sat_clr,
  input logic              out_valid,
  input logic [LANES*LW-1:0] result,
  input logic              sat_flag
);
  localparam int VW = LANES * LW;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sat_flag && !sat_clr) |=> sat_flag); // R6
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (sat_clr && !in_valid) |=> !sat_flag); // R6

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && src[VW-1-LW*i]) |=> (result[VW-1-LW*i -: LW] == '0)); // R4
    AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && src[VW-2-LW*i -: 8] == 8'hFF && src[VW-10-LW*i -: 23] != '0)
      |=> (result[VW-1-LW*i -: LW] == '0 && sat_flag)); // R5
    AST_MAX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result[VW-1-LW*i -: LW] == '1) |-> sat_flag); // R3
  end
endmodule

bind vfx_ucvt vfx_ucvt_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .sat_clr(sat_clr),
  .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
);

// File: tb/tb_vfx_ucvt.sv
module tb_vfx_ucvt;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src = '0;
  logic [4:0]   scale = '0;
  logic         flush_dn = 1'b0;
  logic         sat_clr = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         sat_flag;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vfx_ucvt dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .scale(scale),
                .flush_dn(flush_dn), .sat_clr(sat_clr), .out_valid(out_valid),
                .result(result), .sat_flag(sat_flag));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic convert(input logic [127:0] v, input logic [4:0] s, input logic fl, input logic clr);
    @(negedge clk);
    src = v; scale = s; flush_dn = fl; sat_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 out_valid", 128'(out_valid), 0);
    chk("R9 result", result, 0);
    chk("R9 sat_flag", 128'(sat_flag), 0);
  endtask

  task automatic t_lanes;
    convert({32'h3F800000, 32'h3F000000, 32'h3FC00000, 32'h437FC000}, 5'd0, 1'b0, 1'b1);
    chk("R1 lane order s0", result, {32'd1, 32'd0, 32'd1, 32'd255});
    chk("R2 no sat s0", 128'(sat_flag), 0);
    convert({32'h3F800000, 32'h3F000000, 32'h3FC00000, 32'h437FC000}, 5'd8, 1'b0, 1'b1);
    chk("R2 scale 8", result, {32'd256, 32'd128, 32'd384, 32'd65472});
    convert({32'h3E800000, 32'h437FC000, 32'h3F800000, 32'h3F000000}, 5'd3, 1'b0, 1'b1);
    chk("R1 permuted lanes", result, {32'd2, 32'd2046, 32'd8, 32'd4});
  endtask

  task automatic t_upper;
    convert({32'h3F800000, 32'h3FC00000, 32'h4F7FFFFF, 32'h3E800000}, 5'd31, 1'b0, 1'b1);
    chk("R2 scale 31 in range", result[127:64], {32'h80000000, 32'hC0000000});
    chk("R3 scale 31 over", result[63:0], {32'hFFFFFFFF, 32'h20000000});
    chk("R3 over sets flag", 128'(sat_flag), 1);
    convert({32'h4F7FFFFF, 32'h3E800000, 32'h00000000, 32'h3F7FFFFF}, 5'd0, 1'b0, 1'b1);
    chk("R2 max below 2^32", result, {32'hFFFFFF00, 32'd0, 32'd0, 32'd0});
    chk("R2 no sat near max", 128'(sat_flag), 0);
    convert({32'h7F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000}, 5'd0, 1'b0, 1'b1);
    chk("R3 +inf", result, {32'hFFFFFFFF, 32'd1, 32'd1, 32'd1});
    chk("R3 +inf flag", 128'(sat_flag), 1);
  endtask

  task automatic t_negative;
    convert({32'hBE800000, 32'h80000000, 32'h80400000, 32'h3F800000}, 5'd1, 1'b0, 1'b1);
    chk("R4 tiny negatives", result, {32'd0, 32'd0, 32'd0, 32'd2});
    chk("R4 tiny negatives no flag", 128'(sat_flag), 0);
    convert({32'h3F800000, 32'hBE800000, 32'h3F800000, 32'h3F800000}, 5'd2, 1'b0, 1'b1);
    chk("R4 -0.25 scale 2", result, {32'd4, 32'd0, 32'd4, 32'd4});
    chk("R4 -0.25 scale 2 flag", 128'(sat_flag), 1);
    convert({32'h3F800000, 32'h3F800000, 32'hFF800000, 32'h3F800000}, 5'd0, 1'b0, 1'b1);
    chk("R4 -inf", result, {32'd1, 32'd1, 32'd0, 32'd1});
    chk("R4 -inf flag", 128'(sat_flag), 1);
  endtask

  task automatic t_nan;
    convert({32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h7FC00000}, 5'd4, 1'b0, 1'b1);
    chk("R5 qnan", result, {32'd16, 32'd16, 32'd16, 32'd0});
    chk("R5 qnan flag", 128'(sat_flag), 1);
    convert({32'hFFC00001, 32'h3F800000, 32'h3F800000, 32'h3F800000}, 5'd0, 1'b0, 1'b1);
    chk("R5 negative nan", result, {32'd0, 32'd1, 32'd1, 32'd1});
  endtask

  task automatic t_denorm;
    for (int fl = 0; fl < 2; fl++) begin
      convert({32'h007FFFFF, 32'h00000001, 32'h807FFFFF, 32'h3F800000}, 5'd31, fl[0], 1'b1);
      chk($sformatf("R7 denormals flush=%0d", fl), result, {32'd0, 32'd0, 32'd0, 32'h80000000});
      chk($sformatf("R7 no flag flush=%0d", fl), 128'(sat_flag), 0);
    end
  endtask

  task automatic t_sticky;
    convert({4{32'h3F800000}}, 5'd0, 1'b0, 1'b1);
    chk("R6 cleared", 128'(sat_flag), 0);
    convert({32'h7F800000, {3{32'h3F800000}}}, 5'd0, 1'b0, 1'b0);
    chk("R6 set", 128'(sat_flag), 1);
    convert({4{32'h3F800000}}, 5'd0, 1'b0, 1'b0);
    chk("R6 kept by clean conversion", 128'(sat_flag), 1);
    @(negedge clk);
    chk("R6 kept idle", 128'(sat_flag), 1);
    convert({32'h7FC00000, {3{32'h3F800000}}}, 5'd0, 1'b0, 1'b1);
    chk("R6 set beats clear", 128'(sat_flag), 1);
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    chk("R6 clear alone", 128'(sat_flag), 0);
  endtask

  task automatic t_timing;
    logic [127:0] held;
    convert({4{32'h40000000}}, 5'd1, 1'b0, 1'b1);
    chk("R8 out_valid after in_valid", 128'(out_valid), 1);
    held = result;
    chk("R8 result", held, {4{32'd4}});
    @(negedge clk);
    src = '1;
    @(negedge clk);
    chk("R8 out_valid drops", 128'(out_valid), 0);
    chk("R8 result held while idle", result, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lanes();
    t_upper();
    t_negative();
    t_nan();
    t_denorm();
    t_sticky();
    t_timing();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule